// File: doc/BRIEF.md
# Cycle-Counted VGA Scanout with Row Repeat

This block produces a VGA raster straight from the system clock. It does not use a separate pixel clock. Each scanline is a fixed 586-cycle budget, and a new 8-bit colour byte is presented every third cycle of the visible span. That gives 156 pixels across. Horizontal and vertical sync leave on separate pins. The colour byte is driven on eight parallel lines as RGB332, with red in bits 7:5, green in bits 4:2 and blue in bits 1:0. An external resistor network turns these into analog levels.

Pixels come from a framebuffer through a synchronous byte-read port. The block raises a read strobe with an address, and the memory returns the byte on the next cycle. A repeat factor of 1 to 4 shows each stored row on that many consecutive scanlines. This trades vertical resolution for a smaller framebuffer. A second frame shape gives 350 visible lines at about 70 Hz in place of the usual 480 lines at about 60 Hz. Both the repeat factor and the frame shape are sampled only at frame boundaries, so the picture never tears.

Top module: `vga_line_scan`

## Requirements
- R1: A scanline is 586 cycles. Counting the first cycle of a line as cycle 0, horizontal sync is asserted in cycles 0 to 70. It is active low in the 480-line shape and active high in the 350-line shape.
- R2: In the 480-line shape (`short_sel`=0) a frame is 525 lines: lines 0–479 visible, then 10 blank lines, then 2 lines with `vsync` low, then 33 blank lines. `vsync` is high on every other line.
- R3: `fb_rd` is high for exactly one cycle at line cycles 104+3k, for k = 0 to 155, on visible lines only. It is low at all other times.
- R4: While `fb_rd` is high, `fb_addr` equals row × 156 + k, where row is the framebuffer row of the current line.
- R5: The byte returned on `fb_data` in the cycle after a read appears unchanged on `rgb` during line cycles 106+3k to 108+3k.
- R6: `rgb` is zero outside cycles 106 to 573 of a line, and it is zero on every line that is not visible.
- R7: `rep_sel` codes 0, 1, 2 and 3 select repeat factors 1, 2, 3 and 4. Framebuffer row = visible line index ÷ factor, rounded down.
- R8: `rep_sel` and `short_sel` are sampled only in the last cycle of a frame. Changes made at any other point in a frame have no effect.
- R9: While `rst_n` is low, `rgb` is 0, `fb_rd` is 0, `vsync` is 1 and `hsync` is 0. The first frame after reset uses factor 1 and the 480-line shape. Line counting starts on the third rising edge after `rst_n` rises.
- R10: With `short_sel`=1 a frame is 449 lines: 350 visible, 37 blank, 2 lines with `vsync` low, then 60 blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rep_sel | input | 2 | Row repeat code, factor = code + 1 |
| short_sel | input | 1 | 1 selects the 350-line frame shape |
| fb_rd | output | 1 | Framebuffer read strobe |
| fb_addr | output | ADDR_W (17) | Framebuffer byte address |
| fb_data | input | 8 | Byte returned one cycle after the strobe |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync, active low |
| rgb | output | 8 | RGB332 pixel byte |

## Verification
The hardest case to reach from the ports is a configuration change that arrives mid-frame and must be dropped, followed by the value present in the last cycle of the frame, which must take effect. Each frame of the stimulus therefore drives one configuration for the first lines and another from line 2 to the end. The bench then checks the row address of the last visible line in the following frame.

The bench shortens the vertical line counts through parameters so that every factor can be run in both frame shapes. It keeps the horizontal cycle budget at its real value. A per-cycle reference model compares sync, strobe, address and colour on every cycle of every frame.

// File: rtl/vls_pkg.sv
package vls_pkg;

  localparam int PIX_W = 8;

  typedef struct packed {
    logic [1:0] rep;
    logic       short_fr;
  } scan_cfg_t;

endpackage

// File: rtl/vls_rst_sync.sv
module vls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/vls_hgen.sv
module vls_hgen #(
  parameter int SYNC_CYC  = 71,
  parameter int LEAD_CYC  = 35,
  parameter int ACT_CYC   = 468,
  parameter int TRAIL_CYC = 12,
  parameter int PIX_DIV   = 3,
  localparam int LINE_CYC = SYNC_CYC + LEAD_CYC + ACT_CYC + TRAIL_CYC,
  localparam int COLS     = ACT_CYC / PIX_DIV,
  localparam int COL_W    = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             line_end,
  output logic             hs_act,
  output logic             rd_slot,
  output logic             ld_slot,
  output logic             clr_slot,
  output logic [COL_W-1:0] col
);

  localparam int HC_W     = $clog2(LINE_CYC);
  localparam int PH_W     = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
  localparam int ACT_LO   = SYNC_CYC + LEAD_CYC;
  localparam int ACT_HI   = ACT_LO + ACT_CYC - 1;
  localparam int RD_LO    = ACT_LO - 2;
  localparam int RD_HI    = ACT_HI - 2;
  localparam int LD_LO    = ACT_LO - 1;
  localparam int LD_HI    = ACT_HI - 1;

  logic [HC_W-1:0]  hc_q, hc_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             rd_win, ld_win;

  // next-state
  always_comb begin
    line_end = (hc_q == HC_W'(LINE_CYC - 1));
    hc_d     = line_end ? '0 : hc_q + 1'b1;

    if (hc_q == HC_W'(RD_LO - 1))
      ph_d = '0;
    else if (ph_q == PH_W'(PIX_DIV - 1))
      ph_d = '0;
    else
      ph_d = ph_q + 1'b1;

    rd_win   = (hc_q >= HC_W'(RD_LO)) && (hc_q <= HC_W'(RD_HI));
    ld_win   = (hc_q >= HC_W'(LD_LO)) && (hc_q <= HC_W'(LD_HI));
    rd_slot  = rd_win && (ph_q == '0);
    ld_slot  = ld_win && (ph_q == PH_W'(1));
    clr_slot = (hc_q == HC_W'(ACT_HI));
    hs_act   = (hc_q < HC_W'(SYNC_CYC));

    if (line_end)
      col_d = '0;
    else if (rd_slot)
      col_d = col_q + 1'b1;
    else
      col_d = col_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      ph_q  <= '0;
      col_q <= '0;
    end else begin
      hc_q  <= hc_d;
      ph_q  <= ph_d;
      col_q <= col_d;
    end
  end

  assign col = col_q;

  AST_COL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slot |-> (col_q < COL_W'(COLS))); // R4
  AST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_slot |=> !rd_slot); // R3

endmodule

// File: rtl/vls_vgen.sv
module vls_vgen import vls_pkg::*; #(
  parameter int A_VIS  = 480,
  parameter int A_FP   = 10,
  parameter int A_VS   = 2,
  parameter int A_BP   = 33,
  parameter int B_VIS  = 350,
  parameter int B_FP   = 37,
  parameter int B_VS   = 2,
  parameter int B_BP   = 60,
  parameter int COLS   = 156,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic [1:0]        rep_sel,
  input  logic              short_sel,
  output logic              vis_line,
  output logic              vs_act,
  output logic              frame_end,
  output scan_cfg_t         cfg,
  output logic [ADDR_W-1:0] row_base
);

  localparam int TOT_A   = A_VIS + A_FP + A_VS + A_BP;
  localparam int TOT_B   = B_VIS + B_FP + B_VS + B_BP;
  localparam int TOT_MAX = (TOT_A > TOT_B) ? TOT_A : TOT_B;
  localparam int VC_W    = $clog2(TOT_MAX);

  logic [VC_W-1:0]   vc_q, vc_d;
  logic [VC_W-1:0]   vis_n, sync_lo, sync_hi, last_ln;
  scan_cfg_t         cfg_q, cfg_d;
  logic [1:0]        rcnt_q, rcnt_d;
  logic [ADDR_W-1:0] base_q, base_d;

  // next-state
  always_comb begin
    if (cfg_q.short_fr) begin
      vis_n   = VC_W'(B_VIS);
      sync_lo = VC_W'(B_VIS + B_FP);
      sync_hi = VC_W'(B_VIS + B_FP + B_VS);
      last_ln = VC_W'(TOT_B - 1);
    end else begin
      vis_n   = VC_W'(A_VIS);
      sync_lo = VC_W'(A_VIS + A_FP);
      sync_hi = VC_W'(A_VIS + A_FP + A_VS);
      last_ln = VC_W'(TOT_A - 1);
    end

    vis_line  = (vc_q < vis_n);
    vs_act    = (vc_q >= sync_lo) && (vc_q < sync_hi);
    frame_end = line_end && (vc_q == last_ln);

    vc_d   = vc_q;
    cfg_d  = cfg_q;
    rcnt_d = rcnt_q;
    base_d = base_q;
    if (frame_end) begin
      vc_d           = '0;
      cfg_d.rep      = rep_sel;
      cfg_d.short_fr = short_sel;
      rcnt_d         = '0;
      base_d         = '0;
    end else begin
      vc_d = vc_q + 1'b1;
      if (vis_line) begin
        if (rcnt_q == cfg_q.rep) begin
          rcnt_d = '0;
          base_d = base_q + ADDR_W'(COLS);
        end else begin
          rcnt_d = rcnt_q + 1'b1;
        end
      end
    end
  end

  // registers, enabled once per line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc_q   <= '0;
      cfg_q  <= '0;
      rcnt_q <= '0;
      base_q <= '0;
    end else if (line_end) begin
      vc_q   <= vc_d;
      cfg_q  <= cfg_d;
      rcnt_q <= rcnt_d;
      base_q <= base_d;
    end
  end

  assign cfg      = cfg_q;
  assign row_base = base_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_q)); // R8
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(base_q)); // R7
  AST_SYNC_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    vs_act |-> !vis_line); // R2

endmodule

// File: rtl/vga_line_scan.sv
module vga_line_scan import vls_pkg::*; #(
  parameter int SYNC_CYC  = 71,
  parameter int LEAD_CYC  = 35,
  parameter int ACT_CYC   = 468,
  parameter int TRAIL_CYC = 12,
  parameter int PIX_DIV   = 3,
  parameter int A_VIS     = 480,
  parameter int A_FP      = 10,
  parameter int A_VS      = 2,
  parameter int A_BP      = 33,
  parameter int B_VIS     = 350,
  parameter int B_FP      = 37,
  parameter int B_VS      = 2,
  parameter int B_BP      = 60,
  localparam int COLS     = ACT_CYC / PIX_DIV,
  localparam int COL_W    = $clog2(COLS + 1),
  localparam int VIS_MAX  = (A_VIS > B_VIS) ? A_VIS : B_VIS,
  localparam int ADDR_W   = $clog2(VIS_MAX * COLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rep_sel,
  input  logic              short_sel,
  output logic              fb_rd,
  output logic [ADDR_W-1:0] fb_addr,
  input  logic [PIX_W-1:0]  fb_data,
  output logic              hsync,
  output logic              vsync,
  output logic [PIX_W-1:0]  rgb
);

  logic              rst_s_n;
  logic              line_end, hs_act, rd_slot, ld_slot, clr_slot;
  logic [COL_W-1:0]  col;
  logic              vis_line, vs_act, frame_end;
  scan_cfg_t         cfg;
  logic [ADDR_W-1:0] row_base;
  logic [PIX_W-1:0]  rgb_q, rgb_d;
  logic              rgb_en;

  vls_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  vls_hgen #(
    .SYNC_CYC  (SYNC_CYC),
    .LEAD_CYC  (LEAD_CYC),
    .ACT_CYC   (ACT_CYC),
    .TRAIL_CYC (TRAIL_CYC),
    .PIX_DIV   (PIX_DIV)
  ) u_h (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .line_end (line_end),
    .hs_act   (hs_act),
    .rd_slot  (rd_slot),
    .ld_slot  (ld_slot),
    .clr_slot (clr_slot),
    .col      (col)
  );

  vls_vgen #(
    .A_VIS  (A_VIS),  .A_FP (A_FP), .A_VS (A_VS), .A_BP (A_BP),
    .B_VIS  (B_VIS),  .B_FP (B_FP), .B_VS (B_VS), .B_BP (B_BP),
    .COLS   (COLS),
    .ADDR_W (ADDR_W)
  ) u_v (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .line_end  (line_end),
    .rep_sel   (rep_sel),
    .short_sel (short_sel),
    .vis_line  (vis_line),
    .vs_act    (vs_act),
    .frame_end (frame_end),
    .cfg       (cfg),
    .row_base  (row_base)
  );

  // pixel register next-state
  always_comb begin
    rgb_en = clr_slot || (ld_slot && vis_line);
    rgb_d  = clr_slot ? '0 : fb_data;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)
      rgb_q <= '0;
    else if (rgb_en)
      rgb_q <= rgb_d;
  end

  assign fb_rd   = rd_slot && vis_line;
  assign fb_addr = row_base + ADDR_W'(col);
  assign hsync   = cfg.short_fr ? hs_act : !hs_act;
  assign vsync   = !vs_act;
  assign rgb     = rgb_q;

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_s_n)
    !vis_line |-> (rgb_q == '0)); // R6
  AST_SYNC_DARK: assert property (@(posedge clk) disable iff (!rst_s_n)
    hs_act |-> (rgb_q == '0)); // R6
  AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_end |-> (line_end && !vis_line)); // R2

endmodule

// File: tb/tb_vga_line_scan.sv
module tb_vga_line_scan;

  localparam int VA = 12, FA = 1, SA = 2, BA = 1;
  localparam int VB = 9,  FB = 1, SB = 2, BB = 2;
  localparam int LINE = 586;
  localparam int COLS = 156;
  localparam int AW   = $clog2(12 * 156 + 1);

  // stimulus vector: rep_mid, short_mid, rep_end, short_end, expected
  // last-visible-row base address for the frame that follows
  localparam int NV = 7;
  localparam logic [21:0] VEC [NV] = '{
    {2'd3, 1'b1, 2'd1, 1'b0, 16'd780},
    {2'd0, 1'b0, 2'd2, 1'b0, 16'd468},
    {2'd1, 1'b1, 2'd3, 1'b0, 16'd312},
    {2'd2, 1'b0, 2'd0, 1'b1, 16'd1248},
    {2'd0, 1'b0, 2'd1, 1'b1, 16'd624},
    {2'd3, 1'b0, 2'd3, 1'b1, 16'd312},
    {2'd2, 1'b1, 2'd0, 1'b0, 16'd1716}
  };

  logic          clk;
  logic          rst_n;
  logic [1:0]    rep_sel;
  logic          short_sel;
  logic          fb_rd;
  logic [AW-1:0] fb_addr;
  logic [7:0]    fb_data;
  logic          hsync, vsync;
  logic [7:0]    rgb;

  int checks;
  int errors;

  vga_line_scan #(
    .A_VIS (VA), .A_FP (FA), .A_VS (SA), .A_BP (BA),
    .B_VIS (VB), .B_FP (FB), .B_VS (SB), .B_BP (BB)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rep_sel   (rep_sel),
    .short_sel (short_sel),
    .fb_rd     (fb_rd),
    .fb_addr   (fb_addr),
    .fb_data   (fb_data),
    .hsync     (hsync),
    .vsync     (vsync),
    .rgb       (rgb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pix_of(input int a);
    return 8'((a * 37) ^ (a >> 3));
  endfunction

  function automatic int tot_of(input bit s);
    return s ? (VB + FB + SB + BB) : (VA + FA + SA + BA);
  endfunction

  always @(posedge clk) begin
    if (fb_rd) fb_data <= pix_of(int'(fb_addr));
  end

  // reference timing model
  int mh, mv, mrep;
  bit mshort, rs1, rs2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 0; rs2 <= 0; mh <= 0; mv <= 0; mrep <= 1; mshort <= 0;
    end else begin
      rs1 <= 1'b1;
      rs2 <= rs1;
      if (rs2) begin
        if (mh == LINE - 1) begin
          mh <= 0;
          if (mv == tot_of(mshort) - 1) begin
            mv     <= 0;
            mrep   <= int'(rep_sel) + 1;
            mshort <= short_sel;
          end else begin
            mv <= mv + 1;
          end
        end else begin
          mh <= mh + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] r_mid, input logic s_mid,
                           input logic [1:0] r_end, input logic s_end,
                           output int last_base);
    int bad [6];
    int fa [6];
    int fe [6];
    bit done;
    for (int i = 0; i < 6; i++) begin bad[i] = 0; fa[i] = 0; fe[i] = 0; end
    last_base = -1;
    done = 0;
    while (!done) begin
      int v, vsb, row;
      bit onv, e_hs, e_vs, e_rd;
      int e_ad, e_px;
      @(negedge clk);
      if (mh == 0 && mv == 0) begin rep_sel = r_mid; short_sel = s_mid; end
      if (mh == 0 && mv == 2) begin rep_sel = r_end; short_sel = s_end; end
      v    = mshort ? VB : VA;
      vsb  = v + (mshort ? FB : FA);
      onv  = (mv < v);
      row  = mv / mrep;
      e_hs = mshort ? (mh < 71) : !(mh < 71);
      e_vs = !(mv >= vsb && mv < vsb + 2);
      e_rd = onv && mh >= 104 && mh <= 569 && ((mh - 104) % 3 == 0);
      e_ad = row * COLS + (mh - 104) / 3;
      e_px = (onv && mh >= 106 && mh <= 573) ? int'(pix_of(row * COLS + (mh - 106) / 3)) : 0;
      if (hsync !== e_hs && bad[0] == 0) begin bad[0] = 1; fa[0] = hsync; fe[0] = e_hs; end
      if (vsync !== e_vs && bad[1] == 0) begin bad[1] = 1; fa[1] = vsync; fe[1] = e_vs; end
      if (fb_rd !== e_rd && bad[2] == 0) begin bad[2] = 1; fa[2] = fb_rd; fe[2] = e_rd; end
      if (e_rd && int'(fb_addr) != e_ad && bad[3] == 0) begin
        bad[3] = 1; fa[3] = int'(fb_addr); fe[3] = e_ad;
      end
      if (e_px != 0 && int'(rgb) != e_px && bad[4] == 0) begin
        bad[4] = 1; fa[4] = int'(rgb); fe[4] = e_px;
      end
      if (e_px == 0 && rgb !== 8'd0 && bad[5] == 0) begin
        bad[5] = 1; fa[5] = int'(rgb); fe[5] = 0;
      end
      if (fb_rd && mv == v - 1 && mh == 104) last_base = int'(fb_addr);
      if (mh == LINE - 1 && mv == tot_of(mshort) - 1) done = 1;
    end
    chk(bad[0] == 0, "R1 R10 hsync timing/polarity", fa[0], fe[0]);
    chk(bad[1] == 0, "R2 R10 vsync lines", fa[1], fe[1]);
    chk(bad[2] == 0, "R3 read strobe", fa[2], fe[2]);
    chk(bad[3] == 0, "R4 R7 read address", fa[3], fe[3]);
    chk(bad[4] == 0, "R5 pixel byte", fa[4], fe[4]);
    chk(bad[5] == 0, "R6 blanking", fa[5], fe[5]);
  endtask

  bit finished;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lb;
    logic [21:0] cur;
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; rep_sel = 2'd3; short_sel = 1'b1; fb_data = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rgb == 8'd0, "R9 reset rgb", int'(rgb), 0);
    chk(fb_rd == 1'b0, "R9 reset fb_rd", int'(fb_rd), 0);
    chk(vsync == 1'b1, "R9 reset vsync", int'(vsync), 1);
    chk(hsync == 1'b0, "R9 reset hsync", int'(hsync), 0);
    rst_n = 1'b1;

    // first frame: defaults apply regardless of inputs held during reset (R8 R9)
    cur = VEC[0];
    run_frame(cur[21:20], cur[19], cur[18:17], cur[16], lb);
    chk(lb == 1716, "R9 R7 default factor last-row base", lb, 1716);

    for (int k = 1; k <= NV; k++) begin
      logic [21:0] prev;
      prev = VEC[k - 1];
      if (k < NV) begin
        cur = VEC[k];
        run_frame(cur[21:20], cur[19], cur[18:17], cur[16], lb);
      end else begin
        run_frame(prev[18:17], prev[16], prev[18:17], prev[16], lb);
      end
      chk(lb == int'(prev[15:0]), "R7 R8 last-row base after frame-end sampling",
          lb, int'(prev[15:0]));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule